// File: doc/BRIEF.md
# Sequence-Guarded Register Array

This block is a tiny register array of four 5-bit words that is steered by raw array-core controls rather than by a request/acknowledge interface. Each cycle it receives one select line per word, a precharge level, a write enable and a data bus. A tracking state machine decides whether the stream of control values so far forms a legal write. A word is only updated after the full timed handshake has been seen: a precharge with nothing selected, then one selected line, then data held stable under write enable.

If a cycle fits no legal continuation, the block treats the array as corrupted. Every word loses its valid flag and its data, and the tracker parks in an error phase. It leaves that phase on the first cycle with no line selected, which counts as a fresh start. A combinational read port returns any word together with its valid flag. A status output shows the tracker phase, and a one-cycle pulse marks each committed write.

Top module: `gm_array`

## Requirements
- R1: After reset every word reads invalid, the phase output is 0 (idle) and the commit pulse is low.
- R2: At least 10 consecutive cycles with no line selected and precharge high, then any number of unselected cycles, then one selected line i with write enable low, then 6 cycles with only line i selected, write enable high, precharge low and a constant data value d: this commits d to word i on the 6th such cycle. In the cycle after that edge the phase is 4 (post-commit) and the commit pulse is high for exactly one cycle.
- R3: Once the precharge count has reached 10, further unselected cycles keep the tracker armed whatever the precharge level. If the count has not reached 10 when precharge drops, the tracker returns to idle, and a line selected from idle or from an incomplete precharge is illegal.
- R4: A return to no line selected before the 6th data cycle abandons the write without error: the phase becomes idle (0) or precharge (1), and no word changes.
- R5: A data change during the data-hold phase is illegal. Any illegal cycle moves the phase to 5 (error) and clears every word to invalid.
- R6: A select pattern with more than one line high, seen outside the error phase, is illegal.
- R7: A change of the selected line in mid-sequence is illegal.
- R8: In the error phase, any cycle with a line selected keeps the phase at 5. A cycle with no line selected starts afresh (phase 1 with precharge high, 0 otherwise), and a later legal write then commits normally.
- R9: After the commit, the same line may stay selected. The data may change while write enable is low, but a data change while write enable is high is illegal.
- R10: The read port returns the addressed word and its valid flag in the same cycle. An invalid word reads as data 0 with valid low. Phase codes: 0 idle, 1 precharge, 2 select, 3 data-hold, 4 post-commit, 5 error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wl_i | input | 4 | Word select lines, one per word |
| pchg_i | input | 1 | Precharge level |
| we_i | input | 1 | Write enable |
| din_i | input | 5 | Write data bus |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 5 | Read data, 0 when the word is invalid |
| rd_valid_o | output | 1 | Valid flag of the addressed word |
| phase_o | output | 3 | Tracker phase code |
| commit_o | output | 1 | One-cycle pulse after a committed write |

## Verification
The legal write is driven with a bare minimum precharge, with precharge toggled after arming, and with no select-only cycle at all. This shows that only the counts and the order matter. Writes that fall one cycle short, in either the precharge count or the data-hold count, separate a premature commit from a correct abort or poisoning. Corruptions in the form of a changed data value, a multi-line select, a switched line and a late data change after the commit each have to poison all four words. After each one, a fresh legal write confirms that the error phase is left only through an unselected cycle.

// File: rtl/gm_pkg.sv
package gm_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_PCHG = 3'd1,
    PH_SEL  = 3'd2,
    PH_HOLD = 3'd3,
    PH_POST = 3'd4,
    PH_ERR  = 3'd5
  } phase_t;
endpackage

// File: rtl/gm_tracker.sv
module gm_tracker
  import gm_pkg::*;
#(
  parameter int WORDS    = 4,
  parameter int DW       = 5,
  parameter int PRE_MIN  = 10,
  parameter int HOLD_MIN = 6,
  localparam int AW  = $clog2(WORDS),
  localparam int PCW = $clog2(PRE_MIN + 1),
  localparam int HCW = $clog2(HOLD_MIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WORDS-1:0] wl,
  input  logic             pchg,
  input  logic             we,
  input  logic [DW-1:0]    din,
  output logic             commit,
  output logic [AW-1:0]    commit_addr,
  output logic [DW-1:0]    commit_data,
  output logic             poison,
  output phase_t           phase,
  output logic             commit_pulse
);
  localparam logic [PCW-1:0] PCNT_FULL = PCW'(PRE_MIN);
  localparam logic [HCW-1:0] HCNT_FULL = HCW'(HOLD_MIN);

  phase_t         st_q, st_n;
  logic [PCW-1:0] pcnt_q, pcnt_n;
  logic [HCW-1:0] hcnt_q, hcnt_n;
  logic [AW-1:0]  sel_q, sel_n;
  logic [DW-1:0]  dat_q, dat_n;
  logic           pulse_q;

  logic          safe, one, same, armed, data_ok;
  logic [AW-1:0] idx;

  always_comb begin
    idx = '0;
    for (int k = 0; k < WORDS; k++)
      if (wl[k]) idx = AW'(k);
  end

  assign safe    = (wl == '0);
  assign one     = $onehot(wl);
  assign same    = one && (idx == sel_q);
  assign armed   = (pcnt_q == PCNT_FULL);
  assign data_ok = same && we && !pchg;

  always_comb begin
    st_n   = st_q;
    pcnt_n = pcnt_q;
    hcnt_n = hcnt_q;
    sel_n  = sel_q;
    dat_n  = dat_q;
    commit = 1'b0;
    if (safe && !(st_q == PH_PCHG && (armed || pchg))) begin
      // unselected cycle: a fresh start of a sequence
      st_n   = pchg ? PH_PCHG : PH_IDLE;
      pcnt_n = pchg ? PCW'(1) : '0;
    end else begin
      unique case (st_q)
        PH_PCHG: begin
          if (safe) begin
            if (!armed) pcnt_n = pcnt_q + PCW'(1);
          end else if (armed && one && !we) begin
            st_n  = PH_SEL;
            sel_n = idx;
          end else if (armed && one && !pchg) begin
            sel_n  = idx;
            dat_n  = din;
            hcnt_n = HCW'(1);
            commit = (HCW'(1) == HCNT_FULL);
            st_n   = commit ? PH_POST : PH_HOLD;
          end else begin
            st_n = PH_ERR;
          end
        end
        PH_SEL: begin
          if (same && !we) begin
            st_n = PH_SEL;
          end else if (data_ok) begin
            dat_n  = din;
            hcnt_n = HCW'(1);
            commit = (HCW'(1) == HCNT_FULL);
            st_n   = commit ? PH_POST : PH_HOLD;
          end else begin
            st_n = PH_ERR;
          end
        end
        PH_HOLD: begin
          if (data_ok && din == dat_q) begin
            hcnt_n = hcnt_q + HCW'(1);
            commit = (hcnt_n == HCNT_FULL);
            st_n   = commit ? PH_POST : PH_HOLD;
          end else begin
            st_n = PH_ERR;
          end
        end
        PH_POST: begin
          if (same && (!we || din == dat_q)) st_n = PH_POST;
          else                               st_n = PH_ERR;
        end
        default: st_n = PH_ERR;
      endcase
    end
  end

  assign poison      = (st_n == PH_ERR);
  assign commit_addr = sel_n;
  assign commit_data = dat_n;
  assign phase       = st_q;
  assign commit_pulse = pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PH_IDLE;
      pcnt_q  <= '0;
      hcnt_q  <= '0;
      sel_q   <= '0;
      dat_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      pcnt_q  <= pcnt_n;
      hcnt_q  <= hcnt_n;
      sel_q   <= sel_n;
      dat_q   <= dat_n;
      pulse_q <= commit;
    end
  end
endmodule

// File: rtl/gm_store.sv
module gm_store #(
  parameter int WORDS = 4,
  parameter int DW    = 5,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          clear,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic [DW-1:0] mem_q [WORDS];
  logic [WORDS-1:0] vld_q;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic hit;
    assign hit = wr_en && (wr_addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
        vld_q[g] <= 1'b0;
      end else if (clear) begin
        mem_q[g] <= '0;
        vld_q[g] <= 1'b0;
      end else if (hit) begin
        mem_q[g] <= wr_data;
        vld_q[g] <= 1'b1;
      end
    end
  end

  assign rd_valid = vld_q[rd_addr];
  assign rd_data  = rd_valid ? mem_q[rd_addr] : '0;
endmodule

// File: rtl/gm_array.sv
module gm_array
  import gm_pkg::*;
#(
  parameter int WORDS    = 4,
  parameter int DW       = 5,
  parameter int PRE_MIN  = 10,
  parameter int HOLD_MIN = 6,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WORDS-1:0] wl_i,
  input  logic             pchg_i,
  input  logic             we_i,
  input  logic [DW-1:0]    din_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_valid_o,
  output logic [2:0]       phase_o,
  output logic             commit_o
);
  logic          commit, poison;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_data;
  phase_t        phase;

  gm_tracker #(
    .WORDS(WORDS), .DW(DW), .PRE_MIN(PRE_MIN), .HOLD_MIN(HOLD_MIN)
  ) u_trk (
    .clk(clk), .rst_n(rst_n), .wl(wl_i), .pchg(pchg_i), .we(we_i),
    .din(din_i), .commit(commit), .commit_addr(c_addr),
    .commit_data(c_data), .poison(poison), .phase(phase),
    .commit_pulse(commit_o)
  );

  gm_store #(.WORDS(WORDS), .DW(DW)) u_st (
    .clk(clk), .rst_n(rst_n), .wr_en(commit), .wr_addr(c_addr),
    .wr_data(c_data), .clear(poison), .rd_addr(rd_addr_i),
    .rd_data(rd_data_o), .rd_valid(rd_valid_o)
  );

  assign phase_o = phase;
endmodule

// File: rtl/gm_array_chk.sv
module gm_array_chk #(
  parameter int WORDS = 4,
  parameter int DW    = 5,
  localparam int AW = $clog2(WORDS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WORDS-1:0] wl_i,
  input logic [DW-1:0]    rd_data_o,
  input logic             rd_valid_o,
  input logic [2:0]       phase_o,
  input logic             commit_o
);
  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);

  assert_pulse_in_post_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (phase_o == 3'd4));

  assert_pulse_from_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> ($past(phase_o) == 3'd3 || $past(phase_o) == 3'd2 ||
                  $past(phase_o) == 3'd1));

  assert_error_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd5) |-> !rd_valid_o);

  assert_multi_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(wl_i) > 1) |=> (phase_o == 3'd5));

  assert_error_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd5 && wl_i != '0) |=> (phase_o == 3'd5));

  assert_invalid_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_o |-> (rd_data_o == '0));
endmodule

bind gm_array gm_array_chk #(.WORDS(WORDS), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wl_i(wl_i), .rd_data_o(rd_data_o),
  .rd_valid_o(rd_valid_o), .phase_o(phase_o), .commit_o(commit_o)
);

// File: tb/tb_gm_array.sv
module tb_gm_array;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] wl;
  logic       pchg, we;
  logic [4:0] din;
  logic [1:0] rd_addr;
  logic [4:0] rd_data;
  logic       rd_valid;
  logic [2:0] phase;
  logic       commit;

  always #10 clk = ~clk;

  gm_array dut (
    .clk(clk), .rst_n(rst_n), .wl_i(wl), .pchg_i(pchg), .we_i(we),
    .din_i(din), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .phase_o(phase), .commit_o(commit)
  );

  typedef struct {
    bit         is_read;
    logic [1:0] addr;
    logic [4:0] data;
    logic       valid;
    logic [2:0] ph;
    logic       pulse;
    string      req;
  } item_t;

  item_t q[$];
  int pending = 0;
  int n_chk = 0, n_fail = 0;
  logic [4:0] m_d [4];
  logic       m_v [4];

  // monitor: pops expected items and compares against the ports
  initial begin
    rd_addr = '0;
    forever begin
      item_t it;
      wait (pending > 0);
      it = q.pop_front();
      if (it.is_read) begin
        rd_addr = it.addr;
        #1;
        n_chk++;
        if (rd_data !== it.data || rd_valid !== it.valid) begin
          n_fail++;
          $display("FAIL %s: word %0d got data=%0d valid=%b, expected data=%0d valid=%b",
                   it.req, it.addr, rd_data, rd_valid, it.data, it.valid);
        end
      end else begin
        #1;
        n_chk++;
        if (phase !== it.ph || commit !== it.pulse) begin
          n_fail++;
          $display("FAIL %s: got phase=%0d pulse=%b, expected phase=%0d pulse=%b",
                   it.req, phase, commit, it.ph, it.pulse);
        end
      end
      pending--;
    end
  end

  task automatic put_stat(input logic [2:0] ph, input logic pu, input string req);
    item_t it;
    it.is_read = 0; it.addr = 0; it.data = 0; it.valid = 0;
    it.ph = ph; it.pulse = pu; it.req = req;
    q.push_back(it); pending++;
  endtask

  task automatic put_all(input string req);
    for (int a = 0; a < 4; a++) begin
      item_t it;
      it.is_read = 1; it.addr = 2'(a);
      it.valid = m_v[a]; it.data = m_v[a] ? m_d[a] : 5'd0;
      it.ph = 0; it.pulse = 0; it.req = req;
      q.push_back(it); pending++;
    end
  endtask

  task automatic flush();
    wait (pending == 0);
  endtask

  task automatic cyc(input logic [3:0] w, input logic p, input logic e, input logic [4:0] d);
    @(negedge clk);
    wl = w; pchg = p; we = e; din = d;
    @(posedge clk);
    #3;
  endtask

  function automatic logic [3:0] oh(input int i);
    return 4'(1 << i);
  endfunction

  task automatic poison_model();
    for (int a = 0; a < 4; a++) begin m_v[a] = 1'b0; m_d[a] = '0; end
  endtask

  task automatic arm(input int n);
    for (int k = 0; k < n; k++) cyc(4'b0, 1'b1, 1'b0, 5'd0);
    cyc(4'b0, 1'b0, 1'b0, 5'd0);
  endtask

  task automatic hold(input int i, input logic [4:0] d, input int n);
    for (int k = 0; k < n; k++) cyc(oh(i), 1'b0, 1'b1, d);
  endtask

  task automatic full_write(input int i, input logic [4:0] d, input string req);
    arm(10);
    cyc(oh(i), 1'b0, 1'b0, 5'd0);
    hold(i, d, 6);
    m_d[i] = d; m_v[i] = 1'b1;
    put_stat(3'd4, 1'b1, req); put_all(req); flush();
    cyc(4'b0, 1'b0, 1'b0, 5'd0);
    put_stat(3'd0, 1'b0, req); flush();
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    poison_model();
    rst_n = 1'b0; wl = '0; pchg = 0; we = 0; din = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #3;
    // R1 reset state, R10 invalid words read zero
    put_stat(3'd0, 1'b0, "R1"); put_all("R1/R10"); flush();

    // R2 basic write of 21 into word 2, one select cycle short of nothing
    arm(10);
    put_stat(3'd1, 1'b0, "R2"); flush();
    cyc(oh(2), 1'b0, 1'b0, 5'd0); cyc(oh(2), 1'b0, 1'b0, 5'd0);
    put_stat(3'd2, 1'b0, "R2"); flush();
    hold(2, 5'd21, 5);
    put_stat(3'd3, 1'b0, "R2 no commit after 5"); put_all("R2 no commit after 5"); flush();
    hold(2, 5'd21, 1);
    m_d[2] = 5'd21; m_v[2] = 1'b1;
    put_stat(3'd4, 1'b1, "R2 commit"); put_all("R2/R10 commit"); flush();
    // R9 data may change with write enable low
    cyc(oh(2), 1'b0, 1'b0, 5'd3);
    put_stat(3'd4, 1'b0, "R9 we low"); put_all("R9 we low"); flush();
    cyc(4'b0, 1'b0, 1'b0, 5'd0);
    put_stat(3'd0, 1'b0, "R2 end safe"); flush();

    // R3 armed precharge survives toggling
    for (int k = 0; k < 10; k++) cyc(4'b0, 1'b1, 1'b0, 5'd0);
    cyc(4'b0, 1'b0, 1'b0, 5'd0); cyc(4'b0, 1'b1, 1'b0, 5'd0); cyc(4'b0, 1'b0, 1'b0, 5'd0);
    put_stat(3'd1, 1'b0, "R3 armed"); flush();
    cyc(oh(0), 1'b0, 1'b0, 5'd0);
    hold(0, 5'd10, 6);
    m_d[0] = 5'd10; m_v[0] = 1'b1;
    put_stat(3'd4, 1'b1, "R3/R2 commit word0"); put_all("R2 word0"); flush();
    cyc(4'b0, 1'b0, 1'b0, 5'd0);
    // R2 with no select-only cycle, max data into word 3
    arm(10);
    hold(3, 5'd31, 6);
    m_d[3] = 5'd31; m_v[3] = 1'b1;
    put_stat(3'd4, 1'b1, "R2 direct data"); put_all("R2 word3"); flush();
    cyc(4'b0, 1'b0, 1'b0, 5'd0);

    // R4 abort after 3 data cycles
    arm(10);
    cyc(oh(1), 1'b0, 1'b0, 5'd0);
    hold(1, 5'd7, 3);
    cyc(4'b0, 1'b0, 1'b0, 5'd0);
    put_stat(3'd0, 1'b0, "R4 abort"); put_all("R4 abort"); flush();

    // R3 short precharge (9) then select -> error
    for (int k = 0; k < 9; k++) cyc(4'b0, 1'b1, 1'b0, 5'd0);
    cyc(4'b0, 1'b0, 1'b0, 5'd0);
    put_stat(3'd0, 1'b0, "R3 short idle"); flush();
    cyc(oh(1), 1'b0, 1'b0, 5'd0);
    poison_model();
    put_stat(3'd5, 1'b0, "R3 short error"); put_all("R3/R5 poison"); flush();

    // R8 error sticks, safe restarts
    cyc(oh(0), 1'b0, 1'b0, 5'd0);
    cyc(4'b1111, 1'b1, 1'b1, 5'd4);
    put_stat(3'd5, 1'b0, "R8 sticky"); flush();
    cyc(4'b0, 1'b1, 1'b0, 5'd0);
    put_stat(3'd1, 1'b0, "R8 restart"); flush();
    full_write(1, 5'd9, "R8 recover write");

    // R5 data change in hold
    arm(10);
    cyc(oh(2), 1'b0, 1'b0, 5'd0);
    hold(2, 5'd4, 2);
    cyc(oh(2), 1'b0, 1'b1, 5'd5);
    poison_model();
    put_stat(3'd5, 1'b0, "R5 data change"); put_all("R5 poison"); flush();
    cyc(4'b0, 1'b0, 1'b0, 5'd0);
    full_write(0, 5'd17, "R5 recover write");

    // R6 multi-line select
    arm(10);
    cyc(4'b0101, 1'b0, 1'b0, 5'd0);
    poison_model();
    put_stat(3'd5, 1'b0, "R6 multi select"); put_all("R6 poison"); flush();
    cyc(4'b0, 1'b0, 1'b0, 5'd0);
    full_write(3, 5'd2, "R6 recover write");

    // R7 line change in mid-sequence
    arm(10);
    cyc(oh(3), 1'b0, 1'b0, 5'd0);
    cyc(oh(2), 1'b0, 1'b0, 5'd0);
    poison_model();
    put_stat(3'd5, 1'b0, "R7 line change"); put_all("R7 poison"); flush();
    cyc(4'b0, 1'b0, 1'b0, 5'd0);

    // R9 data change with write enable high after commit
    arm(10);
    cyc(oh(2), 1'b0, 1'b0, 5'd0);
    hold(2, 5'd12, 6);
    m_d[2] = 5'd12; m_v[2] = 1'b1;
    put_stat(3'd4, 1'b1, "R9 commit"); put_all("R9 commit"); flush();
    cyc(oh(2), 1'b0, 1'b1, 5'd12);
    put_stat(3'd4, 1'b0, "R9 same data"); flush();
    cyc(oh(2), 1'b0, 1'b1, 5'd13);
    poison_model();
    put_stat(3'd5, 1'b0, "R9 late change"); put_all("R9 poison"); flush();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule